// File: doc/BRIEF.md
# Embedded Operation Status Readout

This block sits between a flash-style command controller and the data bus. When the controller launches an internal program or erase, a parameterised down-counter times the operation. While that counter runs, a host read gets a status word instead of array data. Bit 7 reports completion by polarity: during a program it is the inverse of bit 7 of the word being written, and during an erase it is 0. Bit 6 flips after every finished read. When the counter expires, reads return array data again with no host action.

The block also gates the bus driver so that it drives only while chip enable and output enable are both low. It holds off all writes for a power-on delay, counted once the supply is reported valid. Reset low aborts a running operation and releases the bus.

The operation timer is a three-state machine. The states are `OP_IDLE`, `OP_PROG` and `OP_ERASE`. The transition *launch-program* goes from `OP_IDLE` to `OP_PROG`, and *launch-erase* goes from `OP_IDLE` to `OP_ERASE`. Both are taken on an accepted start. The transition *expire* returns from either busy state to `OP_IDLE` once the remaining count is zero. Reset low forces `OP_IDLE` from any state. The toggle flip-flop and the power-on lockout counter are plain registers beside it.

Top module: `embop_status`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0 whatever `ce_n` and `oe_n` are, and `write_ok` is 0.
- R2: `dq_oe` is 1 exactly when `rst_n`, `ce_n` = 0 and `oe_n` = 0 all hold, whether or not an operation is running.
- R3: After reset, `write_ok` stays 0 and `cmd_start` is refused until `supply_ok` has been 1 on POR_CYC consecutive rising clock edges. `write_ok` rises right after the POR_CYC-th such edge. A 0 on `supply_ok` at any edge restarts the count.
- R4: A program start is taken on a clock edge where `cmd_start` = 1, `cmd_erase` = 0, `write_ok` = 1. The operation is then busy (`write_ok` = 0, status on the bus) for exactly PROG_CYC clock cycles after that edge.
- R5: An erase start (`cmd_erase` = 1) behaves like R4 but stays busy for exactly ERASE_CYC cycles.
- R6: During a program, bus bit 7 reads as the inverse of bit 7 of `cmd_wdata` captured at the accepted start.
- R7: During an erase, bus bit 7 reads 0.
- R8: Bus bit 6 reads 0 on the first read after an accepted start. While busy, it inverts after each completed read, meaning a read seen active on one clock edge and inactive on a later edge. Once idle, bit 6 no longer toggles and carries array data.
- R9: During any operation, bus bits other than 7 and 6 read 0.
- R10: When idle, `dq_out` equals `array_rdata`.
- R11: `cmd_start` while busy is ignored. It neither restarts the timer nor changes its type or the captured bit 7.
- R12: Reset low during an operation aborts it. After reset is released, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-valid indication |
| cmd_start | input | 1 | Launch request from command controller |
| cmd_erase | input | 1 | 1 = erase, 0 = program, qualifies `cmd_start` |
| cmd_wdata | input | DW | Last word written by the controller |
| array_rdata | input | DW | Array read data for the current address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_out | output | DW | Read data or status word |
| dq_oe | output | 1 | Bus driver enable |
| write_ok | output | 1 | Writes accepted: lockout over and no operation running |

## Verification
The bench builds the block with PROG_CYC = 5, ERASE_CYC = 12 and POR_CYC = 6. These values let it check every busy window cycle by cycle and walk the whole lockout count, including a restart part way through. They also make room for a program run for all 256 values of the low data byte, which covers both polarities of the polling bit against many array patterns. The 12-cycle erase leaves space for four two-cycle read pulses, so the toggle sequence 0,1,0,1 and its stop after completion can be observed.

// File: rtl/embop_pkg.sv
package embop_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_state_t;
endpackage

// File: rtl/embop_por_lock.sv
module embop_por_lock #(
    parameter int POR_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic por_ok
);
    localparam int PW = $clog2(POR_CYC + 1);
    localparam logic [PW-1:0] LIMIT = PW'(POR_CYC);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!supply_ok)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign por_ok = (cnt == LIMIT);

    // R3: every valid-supply edge before the limit advances the count by one
    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !por_ok) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/embop_op_timer.sv
module embop_op_timer
    import embop_pkg::*;
#(
    parameter int PROG_CYC  = 2500,
    parameter int ERASE_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    input  logic wr_bit7,
    input  logic allow,
    output logic busy,
    output logic erasing,
    output logic poll_val,
    output logic launch
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYC - 1);

    op_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          poll_q;

    assign launch = start && allow && (state == OP_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OP_IDLE;
            cnt    <= '0;
            poll_q <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (launch)
                poll_q <= is_erase ? 1'b0 : ~wr_bit7;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            OP_IDLE: begin
                if (launch) begin
                    state_n = is_erase ? OP_ERASE : OP_PROG;
                    cnt_n   = is_erase ? ERASE_LOAD : PROG_LOAD;
                end
            end
            OP_PROG, OP_ERASE: begin
                if (cnt == '0)
                    state_n = OP_IDLE;
                else
                    cnt_n = cnt - 1'b1;
            end
            default: begin
                state_n = OP_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state != OP_IDLE);
        erasing  = (state == OP_ERASE);
        poll_val = poll_q;
    end

    // R4, R5: a running operation loses exactly one count per cycle
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R11: the operation type is held until the count is spent
    a_r11_type_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (state == $past(state) && $stable(poll_q)));
endmodule

// File: rtl/embop_toggle.sv
module embop_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    input  logic clr,
    input  logic busy,
    output logic tog
);
    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (clr)
                tog <= 1'b0;
            else if (busy && rd_q && !rd_act)
                tog <= ~tog;
        end
    end

    // R8: no movement of the toggle while no operation runs
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> $stable(tog));
endmodule

// File: rtl/embop_readout.sv
module embop_readout #(
    parameter int DW = 16
) (
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          busy,
    input  logic          poll_val,
    input  logic          tog,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rd_act
);
    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;

    logic [DW-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[POLL_POS] = poll_val;
        status_word[TOG_POS]  = tog;
    end

    always_comb begin
        rd_act = !ce_n && !oe_n;
        dq_oe  = rst_n && rd_act;
        dq_out = busy ? status_word : array_rdata;
    end

    initial begin
        a_r9_width_ok: assert (DW > POLL_POS);
    end
endmodule

// File: rtl/embop_status.sv
module embop_status #(
    parameter int DW        = 16,
    parameter int PROG_CYC  = 2500,
    parameter int ERASE_CYC = 5000000,
    parameter int POR_CYC   = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          cmd_start,
    input  logic          cmd_erase,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] array_rdata,
    input  logic          ce_n,
    input  logic          oe_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          write_ok
);
    logic por_ok;
    logic busy;
    logic erasing;
    logic poll_val;
    logic launch;
    logic tog;
    logic rd_act;

    embop_por_lock #(.POR_CYC(POR_CYC)) i_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .por_ok    (por_ok)
    );

    embop_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .is_erase (cmd_erase),
        .wr_bit7  (cmd_wdata[7]),
        .allow    (por_ok),
        .busy     (busy),
        .erasing  (erasing),
        .poll_val (poll_val),
        .launch   (launch)
    );

    embop_toggle i_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_act (rd_act),
        .clr    (launch),
        .busy   (busy),
        .tog    (tog)
    );

    embop_readout #(.DW(DW)) i_rd (
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .busy        (busy),
        .poll_val    (poll_val),
        .tog         (tog),
        .array_rdata (array_rdata),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .rd_act      (rd_act)
    );

    assign write_ok = por_ok && !busy;

    // R3: while locked out, an idle block stays idle
    a_r3_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_ok && !busy) |=> !busy);

    // R7: an erase never shows a 1 on the polling bit
    a_r7_erase_low: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> !dq_out[7]);
endmodule

// File: tb/test_embop_status.sv
module test_embop_status;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int PC  = 5;
    localparam int EC  = 12;
    localparam int PORC = 6;

    logic clk = 1'b0;
    logic rst_n, supply_ok, cmd_start, cmd_erase, ce_n, oe_n;
    logic [DW-1:0] cmd_wdata, array_rdata, dq_out;
    logic dq_oe, write_ok;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    embop_status #(.DW(DW), .PROG_CYC(PC), .ERASE_CYC(EC), .POR_CYC(PORC)) i_embop_status (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmd_start(cmd_start),
        .cmd_erase(cmd_erase), .cmd_wdata(cmd_wdata), .array_rdata(array_rdata),
        .ce_n(ce_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .write_ok(write_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    // wait for lockout to end, checking the exact edge (R3)
    task automatic por_walk();
        for (int i = 1; i < PORC; i++) begin
            nxt();
            chk("R3 lockout", 32'(write_ok), 32'd0);
        end
        nxt();
        chk("R3 lockout end", 32'(write_ok), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; cmd_start = 1'b0; cmd_erase = 1'b0;
        cmd_wdata = '0; array_rdata = 16'h1234; ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) nxt();
        // R1 reset state
        chk("R1 bus released in reset", 32'(dq_oe), 32'd0);
        chk("R1 no write in reset", 32'(write_ok), 32'd0);

        // R3 lockout walk with a start request held and reads active
        @(negedge clk);
        rst_n = 1'b1; cmd_start = 1'b1; cmd_erase = 1'b1;
        for (int i = 1; i < PORC; i++) begin
            nxt();
            chk("R3 locked", 32'(write_ok), 32'd0);
            chk("R3 start refused", 32'(dq_out), 32'h1234);
        end
        cmd_start = 1'b0;
        nxt();
        chk("R3 lockout end", 32'(write_ok), 32'd1);
        chk("R10 idle array", 32'(dq_out), 32'h1234);

        // R3 restart on supply drop
        supply_ok = 1'b0;
        nxt();
        chk("R3 supply drop", 32'(write_ok), 32'd0);
        supply_ok = 1'b1;
        por_walk();

        // R2 gating sweep while idle
        for (int c = 0; c < 4; c++) begin
            ce_n = c[1]; oe_n = c[0];
            #1;
            chk("R2 gate idle", 32'(dq_oe), 32'((c == 0) ? 1 : 0));
        end
        ce_n = 1'b1; oe_n = 1'b1;

        // R4 R6 R9 R10 program sweep over the low data byte
        for (int d = 0; d < 256; d++) begin
            @(negedge clk);
            cmd_start = 1'b1; cmd_erase = 1'b0;
            cmd_wdata = {8'hA5, 8'(d)};
            array_rdata = 16'(d * 257) ^ 16'hC3A5;
            nxt();
            cmd_start = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
            #1;
            chk("R6 R9 program status", 32'(dq_out), 32'({~d[7], 7'b0}));
            chk("R2 gate busy", 32'(dq_oe), 32'd1);
            chk("R4 busy", 32'(write_ok), 32'd0);
            oe_n = 1'b1;
            #1;
            chk("R2 gate busy off", 32'(dq_oe), 32'd0);
            for (int i = 1; i < PC; i++) begin
                nxt();
                chk("R4 busy window", 32'(write_ok), 32'd0);
            end
            nxt();
            chk("R4 done", 32'(write_ok), 32'd1);
            oe_n = 1'b0;
            #1;
            chk("R10 back to array", 32'(dq_out), 32'(16'(d * 257) ^ 16'hC3A5));
            ce_n = 1'b1; oe_n = 1'b1;
        end

        // R5 R7 R8 erase with read pulses
        array_rdata = 16'h0F0F;
        @(negedge clk);
        cmd_start = 1'b1; cmd_erase = 1'b1; cmd_wdata = 16'h0000;
        nxt();
        cmd_start = 1'b0;
        for (int j = 0; j < 4; j++) begin
            ce_n = 1'b0; oe_n = 1'b0;
            #1;
            chk("R7 R8 R9 erase status", 32'(dq_out), 32'((j % 2) << 6));
            nxt();
            oe_n = 1'b1;
            nxt();
        end
        chk("R5 busy", 32'(write_ok), 32'd0);
        for (int i = 0; i < EC - 9; i++) begin
            nxt();
            chk("R5 busy window", 32'(write_ok), 32'd0);
        end
        nxt();
        chk("R5 done", 32'(write_ok), 32'd1);
        for (int j = 0; j < 2; j++) begin
            oe_n = 1'b0;
            #1;
            chk("R8 no toggle when idle", 32'(dq_out), 32'h0F0F);
            nxt();
            oe_n = 1'b1;
            nxt();
        end
        ce_n = 1'b1;

        // R11 start while busy ignored
        @(negedge clk);
        cmd_start = 1'b1; cmd_erase = 1'b0; cmd_wdata = 16'h0000;
        nxt();
        cmd_erase = 1'b1; cmd_wdata = 16'h00FF;
        nxt();
        nxt();
        cmd_start = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R11 type and bit kept", 32'(dq_out), 32'h0080);
        ce_n = 1'b1; oe_n = 1'b1;
        for (int i = 3; i < PC; i++) begin
            nxt();
            chk("R11 no restart busy", 32'(write_ok), 32'd0);
        end
        nxt();
        chk("R11 ends on time", 32'(write_ok), 32'd1);

        // R12 reset abort
        @(negedge clk);
        cmd_start = 1'b1; cmd_erase = 1'b1;
        nxt();
        cmd_start = 1'b0;
        repeat (3) nxt();
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R12 R1 bus off in reset", 32'(dq_oe), 32'd0);
        nxt();
        rst_n = 1'b1;
        #1;
        chk("R12 bus back", 32'(dq_oe), 32'd1);
        chk("R12 array after abort", 32'(dq_out), 32'h0F0F);
        chk("R12 lockout again", 32'(write_ok), 32'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        por_walk();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule